// File: doc/BRIEF.md
# Page-Cacheability Attribute Driver

This block produces the per-bus-cycle attribute pin that tells external cache logic whether the page being accessed must be treated as uncacheable, together with that pin's output enable. It follows the bus cycle from the address-strobe clock through the last ready strobe the cycle expects. A line (burst) cycle expects four ready strobes and a single transfer expects one. The page-disable value is captured when the address strobe is accepted and is presented unchanged for the whole window.

Whether a window opens, and whether the pin is actually driven in a given clock, depends on several qualifiers. These are the cycle kind, the processor run state, the address-hold input, back-off, hold-acknowledge, reset, init and probe-ready. Back-off releases the pin one clock after it is seen and aborts the open cycle. Hold-acknowledge, init, probe-ready, reset and the stop-clock state release it in the same clock. When the pin is not driven, the enable is low and the value output is held at 0 so that it is always defined.

A high attribute value marks the page uncacheable. A low value does not by itself make the page cacheable, because other signals take part in that decision. That decision is outside this block.

Top module: `pgattr_drive`

## Requirements
- R1: While `rst` is high, `attr_oe` and `attr_out` are 0, and no bus cycle is tracked after reset ends.
- R2: A window opens in the clock where `addr_strobe` is high for cycle kinds memory (`cyc_kind`=0), locked (1) or writeback (2) in run state normal (`run_state`=0), and `attr_oe` is 1 in that same clock.
- R3: The window stays open through the clock in which the last expected `burst_rdy` is sampled: four ready strobes when `burst` was high at the strobe, one otherwise. `burst_rdy` in the strobe clock itself is not counted. `attr_oe` is 0 in the clock after the last ready strobe unless a new window opens there.
- R4: `attr_out` equals `page_dis` in the strobe clock and keeps that captured value for the rest of the window, whatever `page_dis` does later.
- R5: Special cycles (`cyc_kind`=3) and interrupt-acknowledge cycles (4) never open a window, and ready strobes that follow them do not drive the pin.
- R6: In run states shutdown (1), halt (2) and stop-grant (3), a window opens only for a writeback (`cyc_kind`=2) with `snoop_wb` high. Any other strobe in these states leaves the pin undriven.
- R7: `attr_oe` is 0 in every clock in which `hold_ack`, `init_req`, `probe_rdy` or `rst` is high, or `run_state` is stop-clock (4). An open window keeps counting ready strobes while the pin is floated this way.
- R8: When `backoff` is high in a clock, the pin is still driven in that clock if a window is open, and is undriven from the next clock on. The open cycle is aborted. No window opens while `backoff` is high or in the clock right after it.
- R9: A strobe with `addr_hold` high opens no window. A window already open when `addr_hold` rises keeps driving to its last ready strobe.
- R10: Whenever `attr_oe` is 0, `attr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also a float qualifier |
| addr_strobe | input | 1 | Start of a bus cycle |
| burst_rdy | input | 1 | Ready strobe for one transfer |
| burst | input | 1 | Cycle at the strobe is a line (4-beat) transfer |
| addr_hold | input | 1 | Address hold from the system |
| backoff | input | 1 | Back-off from the system |
| hold_ack | input | 1 | Bus hold acknowledge |
| init_req | input | 1 | Init in progress |
| probe_rdy | input | 1 | Debug probe ready |
| cyc_kind | input | 3 | 0 memory, 1 locked, 2 writeback, 3 special, 4 interrupt-ack |
| snoop_wb | input | 1 | Writeback is caused by an inquire cycle |
| run_state | input | 3 | 0 normal, 1 shutdown, 2 halt, 3 stop-grant, 4 stop-clock |
| page_dis | input | 1 | Registered page-disable value for this access |
| attr_out | output | 1 | Attribute value (1 = uncacheable) |
| attr_oe | output | 1 | Output enable for the attribute pin |

## Verification
The checker assumes that `addr_strobe` is not raised again while a window is still open, so a strobe clock always belongs to a new cycle. It also assumes that a strobe never overlaps a float qualifier from an earlier window. The value-stability and cycle-kind properties depend on this. The stimulus follows these rules: each bus cycle is sent as one strobe followed by its full set of ready strobes, or is cut off by back-off, before the next strobe. Hold-acknowledge, init, probe-ready and stop-clock pulses are placed only inside windows or in idle gaps. Ready strobes after rejected strobes are issued alone, with no new strobe, so the check that they leave the pin undriven is not masked.

// File: rtl/pgattr_pkg.sv
package pgattr_pkg;

    typedef enum logic [2:0] {
        CYC_MEM     = 3'd0,
        CYC_LOCKED  = 3'd1,
        CYC_WBACK   = 3'd2,
        CYC_SPECIAL = 3'd3,
        CYC_INTACK  = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        RUN_NORMAL    = 3'd0,
        RUN_SHUTDOWN  = 3'd1,
        RUN_HALT      = 3'd2,
        RUN_STOPGRANT = 3'd3,
        RUN_STOPCLK   = 3'd4
    } run_state_e;

    localparam int LINE_BEATS_DEF = 4;

    // Cycle kinds that carry the attribute at all
    function automatic logic kind_carries(input logic [2:0] k);
        return (k == CYC_MEM) || (k == CYC_LOCKED) || (k == CYC_WBACK);
    endfunction

    // Run state admits a new window for this cycle
    function automatic logic state_admits(input logic [2:0] s,
                                          input logic [2:0] k,
                                          input logic       snoop);
        logic ok;
        case (s)
            RUN_NORMAL:    ok = 1'b1;
            RUN_SHUTDOWN,
            RUN_HALT,
            RUN_STOPGRANT: ok = (k == CYC_WBACK) && snoop;
            default:       ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pgattr_qualify.sv
module pgattr_qualify
    import pgattr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_strobe,
    input  logic       addr_hold,
    input  logic       backoff,
    input  logic       hold_ack,
    input  logic       init_req,
    input  logic       probe_rdy,
    input  logic [2:0] cyc_kind,
    input  logic       snoop_wb,
    input  logic [2:0] run_state,
    input  logic       win_open,
    output logic       start,
    output logic       float_now
);
    logic boff_seen;

    // Remembers back-off from the previous clock; no reset so that
    // the one-clock release also spans the end of reset.
    always_ff @(posedge clk) begin
        boff_seen <= backoff;
    end

    always_comb begin
        float_now = rst | hold_ack | init_req | probe_rdy |
                    (run_state == RUN_STOPCLK);
    end

    always_comb begin
        start = addr_strobe && !win_open && !addr_hold &&
                !backoff && !boff_seen && !float_now &&
                kind_carries(cyc_kind) &&
                state_admits(run_state, cyc_kind, snoop_wb);
    end

endmodule

// File: rtl/pgattr_window.sv
module pgattr_window #(
    parameter int LINE_BEATS = 4,
    localparam int CNT_W     = $clog2(LINE_BEATS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic line_xfer,
    input  logic rdy,
    input  logic pd_in,
    output logic open_q,
    output logic pd_q
);
    localparam logic [CNT_W-1:0] LINE_CNT   = CNT_W'(LINE_BEATS);
    localparam logic [CNT_W-1:0] SINGLE_CNT = CNT_W'(1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            left_q <= '0;
            pd_q   <= 1'b0;
        end else if (abort) begin
            open_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            open_q <= 1'b1;
            left_q <= line_xfer ? LINE_CNT : SINGLE_CNT;
            pd_q   <= pd_in;
        end else if (open_q && rdy) begin
            left_q <= left_q - 1'b1;
            if (left_q == SINGLE_CNT) begin
                open_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pgattr_drive.sv
module pgattr_drive
    import pgattr_pkg::*;
#(
    parameter int LINE_BEATS = LINE_BEATS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_strobe,
    input  logic       burst_rdy,
    input  logic       burst,
    input  logic       addr_hold,
    input  logic       backoff,
    input  logic       hold_ack,
    input  logic       init_req,
    input  logic       probe_rdy,
    input  logic [2:0] cyc_kind,
    input  logic       snoop_wb,
    input  logic [2:0] run_state,
    input  logic       page_dis,
    output logic       attr_out,
    output logic       attr_oe
);
    logic start;
    logic float_now;
    logic win_open;
    logic pd_held;

    pgattr_qualify u_qual (
        .clk        (clk),
        .rst        (rst),
        .addr_strobe(addr_strobe),
        .addr_hold  (addr_hold),
        .backoff    (backoff),
        .hold_ack   (hold_ack),
        .init_req   (init_req),
        .probe_rdy  (probe_rdy),
        .cyc_kind   (cyc_kind),
        .snoop_wb   (snoop_wb),
        .run_state  (run_state),
        .win_open   (win_open),
        .start      (start),
        .float_now  (float_now)
    );

    pgattr_window #(.LINE_BEATS(LINE_BEATS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (backoff),
        .line_xfer(burst),
        .rdy      (burst_rdy),
        .pd_in    (page_dis),
        .open_q   (win_open),
        .pd_q     (pd_held)
    );

    always_comb begin
        attr_oe  = (start | win_open) & ~float_now;
        attr_out = attr_oe & (start ? page_dis : pd_held);
    end

endmodule

// File: rtl/pgattr_drive_chk.sv
module pgattr_drive_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr_strobe,
    input logic       addr_hold,
    input logic       backoff,
    input logic       hold_ack,
    input logic       init_req,
    input logic       probe_rdy,
    input logic [2:0] cyc_kind,
    input logic       snoop_wb,
    input logic [2:0] run_state,
    input logic       attr_out,
    input logic       attr_oe
);
    // R7
    float_imm_chk: assert property (@(posedge clk)
        attr_oe |-> !(rst || hold_ack || init_req || probe_rdy || run_state == 3'd4));

    // R8
    boff_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(backoff) |-> !attr_oe);

    // R10
    idle_value_chk: assert property (@(posedge clk) disable iff (rst)
        !attr_oe |-> !attr_out);

    // R4
    value_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (attr_oe && $past(attr_oe) && !addr_strobe) |-> $stable(attr_out));

    // R5
    kind_chk: assert property (@(posedge clk) disable iff (rst)
        (attr_oe && addr_strobe) |-> (cyc_kind <= 3'd2));

    // R6
    low_power_chk: assert property (@(posedge clk) disable iff (rst)
        (attr_oe && addr_strobe && run_state != 3'd0) |-> (cyc_kind == 3'd2 && snoop_wb));

    // R9
    ahold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && addr_hold && !$past(attr_oe)) |-> !attr_oe);

endmodule

bind pgattr_drive pgattr_drive_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_strobe(addr_strobe),
    .addr_hold  (addr_hold),
    .backoff    (backoff),
    .hold_ack   (hold_ack),
    .init_req   (init_req),
    .probe_rdy  (probe_rdy),
    .cyc_kind   (cyc_kind),
    .snoop_wb   (snoop_wb),
    .run_state  (run_state),
    .attr_out   (attr_out),
    .attr_oe    (attr_oe)
);

// File: tb/pgattr_drive_bench.sv
module pgattr_drive_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst, addr_strobe, burst_rdy, burst, addr_hold, backoff;
    logic       hold_ack, init_req, probe_rdy, snoop_wb, page_dis;
    logic [2:0] cyc_kind, run_state;
    logic       attr_out, attr_oe;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pgattr_drive u_pgattr_drive (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .burst_rdy(burst_rdy),
        .burst(burst), .addr_hold(addr_hold), .backoff(backoff),
        .hold_ack(hold_ack), .init_req(init_req), .probe_rdy(probe_rdy),
        .cyc_kind(cyc_kind), .snoop_wb(snoop_wb), .run_state(run_state),
        .page_dis(page_dis), .attr_out(attr_out), .attr_oe(attr_oe)
    );

    // Behavioural reference: open flag, beats still owed, captured value
    bit m_open = 0;
    int m_left = 0;
    bit m_pd = 0;
    bit m_boff_prev = 0;

    function automatic bit ref_start();
        bit kind_ok, state_ok;
        kind_ok  = (cyc_kind == 0) || (cyc_kind == 1) || (cyc_kind == 2);
        state_ok = (run_state == 0) ||
                   ((run_state >= 1 && run_state <= 3) && cyc_kind == 2 && snoop_wb);
        return addr_strobe && !m_open && !addr_hold && !backoff && !m_boff_prev &&
               !ref_float() && kind_ok && state_ok;
    endfunction

    function automatic bit ref_float();
        return rst || hold_ack || init_req || probe_rdy || run_state == 4;
    endfunction

    always @(posedge clk) begin
        bit st;
        st = ref_start();
        m_boff_prev <= backoff;
        if (rst) begin
            m_open <= 0; m_left <= 0; m_pd <= 0;
        end else if (backoff) begin
            m_open <= 0; m_left <= 0;
        end else if (st) begin
            m_open <= 1; m_left <= burst ? 4 : 1; m_pd <= page_dis;
        end else if (m_open && burst_rdy) begin
            if (m_left == 1) m_open <= 0;
            m_left <= m_left - 1;
        end
    end

    always @(negedge clk) begin
        bit st, e_oe, e_val;
        if (!done) begin
            st    = ref_start();
            e_oe  = (st || m_open) && !ref_float();
            e_val = e_oe && (st ? page_dis : m_pd);
            compared++;
            if (attr_oe !== e_oe || attr_out !== e_val) begin
                mismatched++;
                $display("FAIL %s t=%0t oe=%b val=%b expected oe=%b val=%b",
                         (attr_oe === e_oe) && !e_oe ? "R10" : cur_req,
                         $time, attr_oe, attr_out, e_oe, e_val);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            addr_strobe = 0;
            burst_rdy   = 0;
        end
    endtask

    task automatic strobe(input int kind, input bit line, input bit pd);
        cyc_kind = 3'(kind); burst = line; page_dis = pd; addr_strobe = 1;
        tick();
    endtask

    task automatic readies(input int n, input int wait_cyc);
        for (int i = 0; i < n; i++) begin
            if (wait_cyc > 0) tick(wait_cyc);
            burst_rdy = 1;
            tick();
        end
    endtask

    initial begin
        rst = 1; addr_strobe = 0; burst_rdy = 0; burst = 0; addr_hold = 0;
        backoff = 0; hold_ack = 0; init_req = 0; probe_rdy = 0; snoop_wb = 0;
        page_dis = 0; cyc_kind = 0; run_state = 0;

        cur_req = "R1";
        #1;
        addr_strobe = 1;          // ignored under reset
        tick(3);
        rst = 0;
        readies(2, 0);            // R1: nothing tracked after reset
        tick(2);

        cur_req = "R2";           // single memory read, pd=1
        strobe(0, 0, 1);
        tick(2);
        readies(1, 0);
        tick();

        cur_req = "R3";           // burst memory, wait states, ready in strobe clock ignored
        cyc_kind = 0; burst = 1; page_dis = 0; addr_strobe = 1; burst_rdy = 1;
        tick();
        readies(4, 1);
        readies(2, 0);            // extra readies: no drive
        tick();

        cur_req = "R4";           // page_dis toggles inside window
        strobe(1, 1, 1);
        page_dis = 0;
        readies(2, 0);
        page_dis = 1;
        readies(1, 1);
        page_dis = 0;
        readies(1, 0);
        strobe(2, 0, 0);          // locked then writeback back to back
        page_dis = 1;
        readies(1, 2);
        tick();

        cur_req = "R5";
        strobe(3, 0, 1);
        readies(1, 0);
        strobe(4, 1, 1);
        readies(4, 0);
        tick();

        cur_req = "R6";
        for (int s = 1; s <= 3; s++) begin
            run_state = 3'(s);
            snoop_wb = 0;
            strobe(0, 0, 1); readies(1, 0);
            strobe(2, 1, 1); readies(4, 0);
            snoop_wb = 1;
            strobe(1, 0, 1); readies(1, 0);
            strobe(2, 1, 1); readies(4, 0);
            tick();
        end
        run_state = 0; snoop_wb = 0;

        cur_req = "R7";
        strobe(0, 1, 1);
        hold_ack = 1; burst_rdy = 1; tick(); hold_ack = 0;
        init_req = 1; tick(); init_req = 0;
        probe_rdy = 1; burst_rdy = 1; tick(); probe_rdy = 0;
        run_state = 4; tick(); run_state = 0;
        readies(2, 0);
        tick();
        hold_ack = 1; strobe(0, 0, 1); hold_ack = 0;   // rejected
        readies(1, 0);
        run_state = 4; strobe(0, 0, 1); run_state = 0;
        readies(1, 0);
        tick();

        cur_req = "R8";
        strobe(0, 1, 1);
        readies(1, 0);
        backoff = 1; tick();
        tick(); backoff = 0;
        strobe(0, 0, 1);          // clock after back-off: rejected
        readies(2, 0);
        strobe(0, 0, 0);          // accepted again
        readies(1, 0);
        backoff = 1; strobe(1, 0, 1); backoff = 0;
        readies(1, 0);
        tick(2);

        cur_req = "R9";
        addr_hold = 1;
        strobe(0, 1, 1);
        readies(4, 0);
        addr_hold = 0;
        strobe(0, 1, 1);
        readies(1, 0);
        addr_hold = 1;
        readies(3, 1);
        addr_hold = 0;
        tick();

        cur_req = "R10";
        page_dis = 1;
        tick(3);
        strobe(2, 0, 1);
        readies(1, 0);
        tick(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule